// File: doc/BRIEF.md
# Indexed Register Slave for a Two-Wire Control Bus

This block is the target side of a two-wire serial control bus. Through it a host reaches a bank of byte-wide configuration and status registers. The bank holds 2^IDX_W entries, which is 128 at the default. Both bus lines are open-drain. The block samples SCL and SDA as plain inputs. To pull SDA low it raises `sda_oe_o`. It never drives SCL: it does not stretch the clock, it does not answer a general call, and it does not arbitrate between masters.

A message opens with a start or a repeated start condition. The first byte carries the 7-bit device address and the direction bit. In a write message the next byte is the index:
- its low 7 bits point at a register;
- its top bit turns automatic index stepping on or off for that message.

Every later byte of a write message is stored at the current index. In a read message the block shifts register contents out at the current index until the master answers with a negative acknowledge. The index is held between messages. A usual read is therefore a short write that sets the index, then a repeated start and a read.

All logic runs on the system clock. Both bus lines pass through synchronisers, and their edges are detected in the system clock domain. The system clock must be at least ten times the bus clock. The rest of the chip sees the bank through a combinational lookup port. Indices below RO_COUNT are read-only: index 0 returns CHIP_ID and index 1 returns CHIP_REV. Writes to them are acknowledged but leave them unchanged.

The controller is one state machine with these states:
- IDLE
- ADDR (shifting the address byte)
- ADDR_ACK
- IDX_BIT (shifting the index byte)
- IDX_ACK
- WR_BIT (shifting a write byte)
- WR_ACK
- RD_BIT (sending a read byte)
- RD_ACK (sampling the master's acknowledge)

Its transitions are:
- Any state goes to ADDR on a start and to IDLE on a stop. The stop takes priority.
- ADDR goes to ADDR_ACK on the falling SCL edge after the eighth bit if the address matches. Otherwise it goes to IDLE.
- ADDR_ACK goes to RD_BIT for a read or to IDX_BIT for a write.
- IDX_BIT goes to IDX_ACK, and IDX_ACK goes to WR_BIT.
- WR_BIT goes to WR_ACK and back again for each byte.
- RD_BIT goes to RD_ACK after the eighth bit.
- RD_ACK goes to RD_BIT when the master acknowledges, and to IDLE on a negative acknowledge.

Every transition other than start and stop happens on a falling SCL edge.

Top module: `cfg_bus_slave`

## Requirements
- R1: A start or repeated start (SDA falling while SCL is high) begins a new message at the address byte. This holds in any state. A stop (SDA rising while SCL is high) ends the message and releases SDA.
- R2: The block acknowledges only the address bytes 0x20 (write) and 0x21 (read), that is device address 0010000. After any other address byte it leaves SDA high in the acknowledge slot and ignores the rest of the message until the next start.
- R3: Bit 0 of the address byte fixes the direction for the whole message: 1 is a read by the master and 0 is a write by the master.
- R4: In a write message the byte after the address byte is the index. It is acknowledged, and its bits 6:0 select the register for the next access.
- R5: When bit 7 of the index byte is 1, the index steps by one after each data byte written or read. It wraps from 127 to 0.
- R6: When bit 7 of the index byte is 0, every data byte of the message uses the same index.
- R7: Each write data byte is acknowledged. After that it is stored at the current index and becomes visible on the lookup port.
- R8: Index 0 reads 0x54 and index 1 reads 0x01, and both are read-only. A write to either is acknowledged but leaves the value unchanged.
- R9: In a read, the register at the current index is sent MSB first. The block changes its SDA drive only after a falling SCL edge, or at a start or stop.
- R10: A negative acknowledge from the master in a read ends the message. SDA is released and stays released until the next start.
- R11: A read message with no index byte starts at the index, and uses the stepping mode, left by the previous message.
- R12: `cfg_data_o` shows the register selected by `cfg_idx_i` without a clock delay.
- R13: After reset the block is idle with SDA released. All writable registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least ten times the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| sda_oe_o | output | 1 | When high, pulls the data line low |
| cfg_idx_i | input | IDX_W | Register index for the system-side lookup |
| cfg_data_o | output | 8 | Contents of the register at `cfg_idx_i` |

## Verification
The checker watches the following on every cycle:
- the state entered after each start or stop;
- that a mismatched address drops back to IDLE without an acknowledge;
- that SDA stays released in IDLE;
- that the SDA drive moves only after a falling SCL edge;
- the index step or hold after each stored byte;
- that a written byte reaches the lookup port;
- that read-only entries hold their value.

Only the bench's scenarios show the rest:
- the bit order and values of bytes shifted out;
- the acknowledge bits as the master sees them;
- wrap from 127 into the read-only entries;
- reads that resume at a held index;
- that the line stays quiet after a negative acknowledge.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_IDX_BIT,
        ST_IDX_ACK,
        ST_WR_BIT,
        ST_WR_ACK,
        ST_RD_BIT,
        ST_RD_ACK
    } fsm_e;

endpackage

// File: rtl/cbs_line_cond.sv
// Synchronises both bus lines and turns their movement into one-cycle events.
module cbs_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_d;
    logic                   sda_d;
    logic                   scl_now;
    logic                   sda_now;

    // Reset to the idle-high bus level so that no event fires out of reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_now;
            sda_d    <= sda_now;
        end
    end

    assign scl_now  = scl_pipe[SYNC_STAGES-1];
    assign sda_now  = sda_pipe[SYNC_STAGES-1];
    assign sda_lvl  = sda_now;
    assign ev_rise  = scl_now & ~scl_d;
    assign ev_fall  = ~scl_now & scl_d;
    assign ev_start = scl_now & scl_d & sda_d & ~sda_now;
    assign ev_stop  = scl_now & scl_d & ~sda_d & sda_now;
endmodule

// File: rtl/cbs_regbank.sv
// Register bank: read-only identity entries at the bottom, writable bytes above.
module cbs_regbank #(
    parameter int         IDX_W    = 7,
    parameter int         RO_COUNT = 2,
    parameter logic [7:0] CHIP_ID  = 8'h54,
    parameter logic [7:0] CHIP_REV = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [7:0]       w_data,
    input  logic [IDX_W-1:0] bus_idx,
    output logic [7:0]       bus_data,
    input  logic [IDX_W-1:0] sys_idx,
    output logic [7:0]       sys_data
);
    localparam int NUM_REGS = 1 << IDX_W;

    logic [NUM_REGS*8-1:0] flat;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        if (g < RO_COUNT) begin : g_ro
            localparam logic [7:0] FIXED = (g == 0) ? CHIP_ID :
                                           (g == 1) ? CHIP_REV : 8'h00;
            assign flat[g*8 +: 8] = FIXED;
        end else begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= 8'h00;
                end else if (we && (w_idx == IDX_W'(g))) begin
                    q <= w_data;
                end
            end
            assign flat[g*8 +: 8] = q;
        end
    end

    assign bus_data = flat[{bus_idx, 3'b000} +: 8];
    assign sys_data = flat[{sys_idx, 3'b000} +: 8];
endmodule

// File: rtl/cfg_bus_slave.sv
// Two-wire bus target with index byte, per-message index stepping and a byte bank.
module cfg_bus_slave
    import cbs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h10,
    parameter int         IDX_W       = 7,
    parameter int         RO_COUNT    = 2,
    parameter logic [7:0] CHIP_ID     = 8'h54,
    parameter logic [7:0] CHIP_REV    = 8'h01,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic [IDX_W-1:0] cfg_idx_i,
    output logic [7:0]       cfg_data_o
);
    localparam logic [3:0] CNT_FULL = 4'(BYTE_BITS);
    localparam logic [3:0] CNT_LAST = 4'(BYTE_BITS - 1);

    logic             sda_s;
    logic             ev_rise;
    logic             ev_fall;
    logic             ev_start;
    logic             ev_stop;

    fsm_e             state;
    fsm_e             state_nx;
    logic [7:0]       shreg;
    logic [7:0]       tx_q;
    logic [3:0]       bit_cnt;
    logic [IDX_W-1:0] idx_q;
    logic             inc_q;
    logic             rw_q;
    logic             mack_q;
    logic             sda_oe;

    logic             byte_done;
    logic             addr_hit;
    logic             bank_we;
    logic [7:0]       rd_byte;

    cbs_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_lvl  (sda_s),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    assign byte_done = ev_fall && (bit_cnt == CNT_FULL);
    assign addr_hit  = (shreg[7:1] == DEV_ADDR);
    assign bank_we   = (state == ST_WR_BIT) && byte_done;

    cbs_regbank #(
        .IDX_W    (IDX_W),
        .RO_COUNT (RO_COUNT),
        .CHIP_ID  (CHIP_ID),
        .CHIP_REV (CHIP_REV)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bank_we),
        .w_idx    (idx_q),
        .w_data   (shreg),
        .bus_idx  (idx_q),
        .bus_data (rd_byte),
        .sys_idx  (cfg_idx_i),
        .sys_data (cfg_data_o)
    );

    // Next-state logic: stop outranks start, which outranks the byte flow.
    always_comb begin
        state_nx = state;
        if (ev_stop) begin
            state_nx = ST_IDLE;
        end else if (ev_start) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (ev_fall)   state_nx = rw_q ? ST_RD_BIT : ST_IDX_BIT;
                ST_IDX_BIT:  if (byte_done) state_nx = ST_IDX_ACK;
                ST_IDX_ACK:  if (ev_fall)   state_nx = ST_WR_BIT;
                ST_WR_BIT:   if (byte_done) state_nx = ST_WR_ACK;
                ST_WR_ACK:   if (ev_fall)   state_nx = ST_WR_BIT;
                ST_RD_BIT:   if (ev_fall && bit_cnt == CNT_LAST) state_nx = ST_RD_ACK;
                ST_RD_ACK:   if (ev_fall)   state_nx = mack_q ? ST_RD_BIT : ST_IDLE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath and line drive.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= 8'h00;
            tx_q    <= 8'h00;
            bit_cnt <= 4'd0;
            idx_q   <= '0;
            inc_q   <= 1'b0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (ev_stop) begin
            sda_oe  <= 1'b0;
            bit_cnt <= 4'd0;
        end else if (ev_start) begin
            sda_oe  <= 1'b0;
            bit_cnt <= 4'd0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    bit_cnt <= 4'd0;
                end
                ST_ADDR: begin
                    if (ev_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        bit_cnt <= 4'd0;
                        if (addr_hit) begin
                            sda_oe <= 1'b1;
                            rw_q   <= shreg[0];
                        end
                    end
                end
                ST_IDX_BIT: begin
                    if (ev_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        bit_cnt <= 4'd0;
                        sda_oe  <= 1'b1;
                        idx_q   <= shreg[IDX_W-1:0];
                        inc_q   <= shreg[7];
                    end
                end
                ST_WR_BIT: begin
                    if (ev_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        bit_cnt <= 4'd0;
                        sda_oe  <= 1'b1;
                        if (inc_q) idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev_fall) begin
                        bit_cnt <= 4'd0;
                        if (rw_q) begin
                            tx_q   <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_IDX_ACK, ST_WR_ACK: begin
                    if (ev_fall) begin
                        bit_cnt <= 4'd0;
                        sda_oe  <= 1'b0;
                    end
                end
                ST_RD_BIT: begin
                    if (ev_fall) begin
                        if (bit_cnt == CNT_LAST) begin
                            bit_cnt <= 4'd0;
                            sda_oe  <= 1'b0;
                            if (inc_q) idx_q <= idx_q + IDX_W'(1);
                        end else begin
                            tx_q    <= {tx_q[6:0], 1'b0};
                            sda_oe  <= ~tx_q[6];
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev_rise) mack_q <= ~sda_s;
                    if (ev_fall && mack_q) begin
                        tx_q   <= rd_byte;
                        sda_oe <= ~rd_byte[7];
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    assign sda_oe_o = sda_oe;
endmodule

// File: rtl/cbs_checker.sv
module cbs_checker
    import cbs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h10,
    parameter int         IDX_W    = 7,
    parameter int         RO_COUNT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_fall,
    input logic             ev_start,
    input logic             ev_stop,
    input fsm_e             state,
    input logic [7:0]       shreg,
    input logic [3:0]       bit_cnt,
    input logic [IDX_W-1:0] idx_q,
    input logic             inc_q,
    input logic             bank_we,
    input logic             sda_oe_o,
    input logic [IDX_W-1:0] cfg_idx_i,
    input logic [7:0]       cfg_data_o
);
    assert_start_enters_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && !ev_stop) |=> (state == ST_ADDR && !sda_oe_o));

    assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (state == ST_IDLE && !sda_oe_o));

    assert_mismatch_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && ev_fall && bit_cnt == 4'd8 && shreg[7:1] != DEV_ADDR)
        |=> (state == ST_IDLE && !sda_oe_o));

    assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe_o);

    assert_sda_changes_on_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_fall || ev_start || ev_stop) |=> $stable(sda_oe_o));

    assert_inc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && inc_q) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));

    assert_fixed_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && !inc_q) |=> $stable(idx_q));

    assert_write_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && int'(idx_q) >= RO_COUNT && cfg_idx_i == idx_q)
        |=> (!$stable(cfg_idx_i) || cfg_data_o == $past(shreg)));

    assert_ro_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && int'(idx_q) < RO_COUNT && cfg_idx_i == idx_q)
        |=> (!$stable(cfg_idx_i) || $stable(cfg_data_o)));
endmodule

bind cfg_bus_slave cbs_checker #(
    .DEV_ADDR (DEV_ADDR),
    .IDX_W    (IDX_W),
    .RO_COUNT (RO_COUNT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_fall    (ev_fall),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop),
    .state      (state),
    .shreg      (shreg),
    .bit_cnt    (bit_cnt),
    .idx_q      (idx_q),
    .inc_q      (inc_q),
    .bank_we    (bank_we),
    .sda_oe_o   (sda_oe_o),
    .cfg_idx_i  (cfg_idx_i),
    .cfg_data_o (cfg_data_o)
);

// File: tb/cfg_bus_slave_tb_top.sv
module cfg_bus_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 10;
    localparam int HIGH       = 20;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       sda_line;
    logic [6:0] cfg_idx = 7'd0;
    logic [7:0] cfg_data;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_bus_slave dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .cfg_idx_i  (cfg_idx),
        .cfg_data_o (cfg_data)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(QTR);
        scl_m = 1'b1; wq(HIGH);
        sda_m = 1'b0; wq(HIGH);
        scl_m = 1'b0; wq(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(QTR);
        scl_m = 1'b1; wq(HIGH);
        sda_m = 1'b1; wq(HIGH);
    endtask

    // Drives one bit; returns the line level sampled mid-high.
    task automatic bus_bit(input logic b, output logic seen);
        sda_m = b; wq(QTR);
        scl_m = 1'b1; wq(HIGH/2);
        seen = sda_line; wq(HIGH/2);
        scl_m = 1'b0; wq(QTR);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic seen;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], seen);
        bus_bit(1'b1, seen);
        acked = ~seen;
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] b);
        logic seen;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, seen);
            b = {b[6:0], seen};
        end
        bus_bit(~master_ack, seen);
    endtask

    task automatic peek(input logic [6:0] idx, output logic [7:0] d);
        cfg_idx = idx; wq(1);
        d = cfg_data;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk(sda_oe == 1'b0, "R13", "sda released after reset", sda_oe, 0);
        peek(7'h10, d); chk(d == 8'h00, "R13", "writable reg 0x10 reset", d, 8'h00);
        peek(7'h00, d); chk(d == 8'h54, "R8", "chip id at reset", d, 8'h54);
        peek(7'h01, d); chk(d == 8'h01, "R8", "revision at reset", d, 8'h01);
    endtask

    task automatic t_write_inc();
        logic a; logic [7:0] d;
        bus_start();
        send_byte(8'h20, a); chk(a, "R2", "write address ack", a, 1);
        send_byte(8'h90, a); chk(a, "R4", "index ack", a, 1);
        send_byte(8'hAA, a); chk(a, "R7", "data0 ack", a, 1);
        send_byte(8'hBB, a); chk(a, "R7", "data1 ack", a, 1);
        send_byte(8'hCC, a); chk(a, "R7", "data2 ack", a, 1);
        bus_stop();
        chk(sda_oe == 1'b0, "R1", "released after stop", sda_oe, 0);
        peek(7'h10, d); chk(d == 8'hAA, "R5", "reg 0x10", d, 8'hAA);
        peek(7'h11, d); chk(d == 8'hBB, "R5", "reg 0x11", d, 8'hBB);
        peek(7'h12, d); chk(d == 8'hCC, "R12", "reg 0x12", d, 8'hCC);
    endtask

    task automatic t_write_fixed();
        logic a; logic [7:0] d;
        bus_start();
        send_byte(8'h20, a);
        send_byte(8'h20, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a); chk(a, "R7", "fixed-mode data ack", a, 1);
        bus_stop();
        peek(7'h20, d); chk(d == 8'h33, "R6", "reg 0x20 holds last byte", d, 8'h33);
        peek(7'h21, d); chk(d == 8'h00, "R6", "reg 0x21 untouched", d, 8'h00);
    endtask

    task automatic t_wrap_ro();
        logic a; logic [7:0] d;
        bus_start();
        send_byte(8'h20, a);
        send_byte(8'hFF, a);
        send_byte(8'h5A, a);
        send_byte(8'h66, a); chk(a, "R8", "write to index 0 acked", a, 1);
        send_byte(8'h77, a); chk(a, "R8", "write to index 1 acked", a, 1);
        send_byte(8'hC3, a);
        bus_stop();
        peek(7'h7F, d); chk(d == 8'h5A, "R5", "reg 127", d, 8'h5A);
        peek(7'h00, d); chk(d == 8'h54, "R8", "chip id kept", d, 8'h54);
        peek(7'h01, d); chk(d == 8'h01, "R8", "revision kept", d, 8'h01);
        peek(7'h02, d); chk(d == 8'hC3, "R5", "wrap reached reg 2", d, 8'hC3);
    endtask

    task automatic t_read_inc();
        logic a; logic [7:0] d;
        bus_start();
        send_byte(8'h20, a);
        send_byte(8'h90, a);
        bus_start();
        send_byte(8'h21, a); chk(a, "R3", "read address ack", a, 1);
        recv_byte(1'b1, d); chk(d == 8'hAA, "R9", "read byte0", d, 8'hAA);
        recv_byte(1'b1, d); chk(d == 8'hBB, "R5", "read byte1", d, 8'hBB);
        recv_byte(1'b0, d); chk(d == 8'hCC, "R5", "read byte2", d, 8'hCC);
        chk(sda_oe == 1'b0, "R10", "released after nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_read_fixed_resume();
        logic a; logic [7:0] d;
        bus_start();
        send_byte(8'h20, a);
        send_byte(8'h20, a);
        bus_start();
        send_byte(8'h21, a);
        recv_byte(1'b1, d); chk(d == 8'h33, "R6", "fixed read first", d, 8'h33);
        recv_byte(1'b0, d); chk(d == 8'h33, "R6", "fixed read second", d, 8'h33);
        bus_stop();
        bus_start();
        send_byte(8'h21, a); chk(a, "R11", "direct read ack", a, 1);
        recv_byte(1'b0, d); chk(d == 8'h33, "R11", "read at held index", d, 8'h33);
        bus_stop();
    endtask

    task automatic t_read_ro();
        logic a; logic [7:0] d;
        bus_start();
        send_byte(8'h20, a);
        send_byte(8'h80, a);
        bus_start();
        send_byte(8'h21, a);
        recv_byte(1'b1, d); chk(d == 8'h54, "R8", "read chip id", d, 8'h54);
        recv_byte(1'b0, d); chk(d == 8'h01, "R8", "read revision", d, 8'h01);
        bus_stop();
    endtask

    task automatic t_bad_addr();
        logic a; logic [7:0] d;
        bus_start();
        send_byte(8'h22, a); chk(!a, "R2", "foreign address nacked", a, 0);
        send_byte(8'h90, a); chk(!a, "R2", "later byte nacked", a, 0);
        send_byte(8'hEE, a); chk(!a, "R2", "data byte nacked", a, 0);
        bus_stop();
        peek(7'h10, d); chk(d == 8'hAA, "R2", "reg 0x10 unchanged", d, 8'hAA);
        bus_start();
        send_byte(8'h41, a); chk(!a, "R2", "foreign read address nacked", a, 0);
        bus_stop();
    endtask

    task automatic t_nack_quiet();
        logic a; logic [7:0] d;
        bus_start();
        send_byte(8'h20, a);
        send_byte(8'h90, a);
        bus_start();
        send_byte(8'h21, a);
        recv_byte(1'b0, d); chk(d == 8'hAA, "R10", "byte before nack", d, 8'hAA);
        recv_byte(1'b0, d); chk(d == 8'hFF, "R10", "line quiet after nack", d, 8'hFF);
        bus_stop();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_write_inc();
        t_write_fixed();
        t_wrap_ro();
        t_read_inc();
        t_read_fixed_resume();
        t_read_ro();
        t_bad_addr();
        t_nack_quiet();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule